// File: doc/BRIEF.md
# Service-Level Output Port Scheduler for a Mesh Router

This block decides, each clock cycle, which flit leaves on one output link of a two-dimensional mesh router. Five input ports feed it: four neighbour directions and the local port. Each input keeps a separate buffer for each of four service levels and offers the front flit of every level at the same time. For each head flit, a small dimension-order helper finds the output that the flit's destination routes to. Only heads that route to this output compete.

The scheduler keeps one free-slot counter for each service level of the downstream stage. Credit pulses raise these counters and sent flits lower them. Each service level has its own wormhole lock, a two-state machine with the states FREE and HELD. In FREE, head flits at that level compete in round-robin order, starting from the level's pointer. When a head that is not also a tail wins, the machine takes the transition CLAIM to HELD and records the winning input. In HELD, only the body and tail flits of the owning input are eligible. Sending the tail takes the transition RELEASE back to FREE and moves the pointer one place past the owner. A single-flit packet (head and tail together) takes the transition PASS: it stays in FREE and moves the pointer. In every other case a state holds (IDLE). Across levels, the lowest-numbered level that has an eligible flit and a nonzero counter wins. The grant and the output flit are combinational in the cycle of the request. Counters, locks and pointers update at the next rising edge.

Top module: `qos_port_sched`

## Requirements
- R1: A synchronous active-high reset makes every level FREE, sets every round-robin pointer to input 0 and sets every free-slot counter to DEPTH (default 4). With no input valid there is no grant.
- R2: A head flit requests this output only if its destination routes here under XY order. Compare X first: destination X greater than the router's X means east (direction 1), less means west (2). If X is equal, compare Y: greater means north (3), less means south (4). If both are equal the flit goes to local (0). The default output direction is 1, at router position (1,1).
- R3: At most one flit is granted per cycle. `out_grant` is zero or one-hot at bit index input*NUM_CLS+level. When `out_vld` is high, `out_src`, `out_cls`, `out_data`, `out_head` and `out_tail` describe the granted flit.
- R4: Among the levels that have an eligible flit and a nonzero free-slot counter, level 0 has the highest priority and level 3 the lowest. The lowest-numbered such level wins.
- R5: A level whose counter is zero gets no grant, and a higher-numbered level with credit may be granted in its place.
- R6: Sending a flit lowers its level's counter by one. A credit pulse raises it by one. Both in the same cycle leave it unchanged. The counter never exceeds DEPTH: a pulse at DEPTH is ignored.
- R7: Once a head that is not a tail is sent at a level, only non-head flits of the owning input are eligible at that level until its tail is sent. Heads from other inputs at that level wait.
- R8: Flits of different levels may interleave on the link cycle by cycle while a level is HELD.
- R9: In FREE, the round-robin search begins at the level's pointer. The pointer moves to winner+1 (mod NUM_IN) only when a tail flit of that level is sent.
- R10: A flit that is both head and tail is a complete packet and does not lock its level.
- R11: A body or tail flit at a level with no lock, or from an input that does not own the lock, is ignored and gets no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | NUM_IN*NUM_CLS | Flit offered, slot input*NUM_CLS+level |
| in_head | input | NUM_IN*NUM_CLS | Offered flit is a packet head |
| in_tail | input | NUM_IN*NUM_CLS | Offered flit is a packet tail |
| in_dst_x | input | NUM_IN*NUM_CLS*CW | Destination column of a head flit |
| in_dst_y | input | NUM_IN*NUM_CLS*CW | Destination row of a head flit |
| in_data | input | NUM_IN*NUM_CLS*DW | Flit payload |
| crd_ret | input | NUM_CLS | One-cycle credit pulse per level |
| out_grant | output | NUM_IN*NUM_CLS | One-hot grant to the winning slot |
| out_vld | output | 1 | A flit is sent this cycle |
| out_data | output | DW | Payload of the sent flit |
| out_cls | output | clog2(NUM_CLS) | Service level of the sent flit |
| out_src | output | clog2(NUM_IN) | Input index of the sent flit |
| out_head | output | 1 | Sent flit is a head |
| out_tail | output | 1 | Sent flit is a tail |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a send and a credit pulse at the same level. The bench drains a level to one slot, then sends and pulses together. It judges the result by whether exactly one more flit passes before the level blocks. The second pair is a priority win at one level and a HELD lock at another. A level-0 single-flit packet arrives while a level-1 packet is mid-flight and a rival head waits. The level-0 flit must be sent first, the lock owner's body and tail must follow, and the rival must be sent only after the tail. Around these cases, sweeps cover every mix of levels and every destination on a 3-bit grid. The expected winner is computed from the lowest set bit and from the XY comparison.

// File: rtl/qos_sched_pkg.sv
package qos_sched_pkg;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    localparam logic [2:0] DIR_LOCAL = 3'd0;
    localparam logic [2:0] DIR_EAST  = 3'd1;
    localparam logic [2:0] DIR_WEST  = 3'd2;
    localparam logic [2:0] DIR_NORTH = 3'd3;
    localparam logic [2:0] DIR_SOUTH = 3'd4;

endpackage

// File: rtl/xy_route.sv
module xy_route
    import qos_sched_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    output logic [2:0]    dir
);
    always_comb begin
        if (dst_x > cur_x)      dir = DIR_EAST;
        else if (dst_x < cur_x) dir = DIR_WEST;
        else if (dst_y > cur_y) dir = DIR_NORTH;
        else if (dst_y < cur_y) dir = DIR_SOUTH;
        else                    dir = DIR_LOCAL;
    end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] win
);
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(start) + k) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                win   = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/credit_ctr.sv
module credit_ctr #(
    parameter int DEPTH = 4,
    parameter int CNTW  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            give,
    output logic [CNTW-1:0] cnt,
    output logic            avail
);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    logic [CNTW-1:0] cnt_nxt;

    always_comb begin
        unique case ({take, give})
            2'b10:   cnt_nxt = cnt - CNTW'(1);
            2'b01:   cnt_nxt = (cnt == FULL) ? cnt : cnt + CNTW'(1);
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= FULL;
        else     cnt <= cnt_nxt;
    end

    assign avail = (cnt != '0);

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt != '0));

    p_cap_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    p_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (take && !give) |=> (cnt == $past(cnt) - CNTW'(1)));

    p_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (take && give) |=> $stable(cnt));
endmodule

// File: rtl/class_lock.sv
module class_lock
    import qos_sched_pkg::*;
#(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win,
    input  logic          win_head,
    input  logic          win_tail,
    input  logic [IW-1:0] win_src,
    output logic          held,
    output logic [IW-1:0] owner,
    output logic [IW-1:0] ptr
);
    lock_state_e   state, state_nxt;
    logic [IW-1:0] owner_nxt, ptr_nxt;

    // Transitions: CLAIM (FREE->HELD), RELEASE (HELD->FREE),
    // PASS (FREE->FREE, single-flit packet), IDLE (no change).
    always_comb begin
        state_nxt = state;
        owner_nxt = owner;
        ptr_nxt   = ptr;
        unique case (state)
            LK_FREE: begin
                if (win && win_head && !win_tail) begin
                    state_nxt = LK_HELD;
                    owner_nxt = win_src;
                end else if (win && win_head && win_tail) begin
                    ptr_nxt = IW'((int'(win_src) + 1) % N);
                end
            end
            LK_HELD: begin
                if (win && win_tail) begin
                    state_nxt = LK_FREE;
                    ptr_nxt   = IW'((int'(win_src) + 1) % N);
                end
            end
            default: state_nxt = LK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_FREE;
            owner <= '0;
            ptr   <= '0;
        end else begin
            state <= state_nxt;
            owner <= owner_nxt;
            ptr   <= ptr_nxt;
        end
    end

    assign held = (state == LK_HELD);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (held && !(win && win_tail)) |=> (held && $stable(owner)));

    p_ptr_still_r9: assert property (@(posedge clk) disable iff (rst)
        !(win && win_tail) |=> $stable(ptr));

    p_ptr_range_r9: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < N);
endmodule

// File: rtl/qos_port_sched.sv
module qos_port_sched
    import qos_sched_pkg::*;
#(
    parameter int NUM_IN   = 5,
    parameter int NUM_CLS  = 4,
    parameter int DW       = 16,
    parameter int CW       = 3,
    parameter int DEPTH    = 4,
    parameter int MY_X     = 1,
    parameter int MY_Y     = 1,
    parameter int OUT_DIR  = 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_IN*NUM_CLS-1:0]          in_vld,
    input  logic [NUM_IN*NUM_CLS-1:0]          in_head,
    input  logic [NUM_IN*NUM_CLS-1:0]          in_tail,
    input  logic [NUM_IN*NUM_CLS*CW-1:0]       in_dst_x,
    input  logic [NUM_IN*NUM_CLS*CW-1:0]       in_dst_y,
    input  logic [NUM_IN*NUM_CLS*DW-1:0]       in_data,
    input  logic [NUM_CLS-1:0]                 crd_ret,
    output logic [NUM_IN*NUM_CLS-1:0]          out_grant,
    output logic                               out_vld,
    output logic [DW-1:0]                      out_data,
    output logic [$clog2(NUM_CLS)-1:0]         out_cls,
    output logic [$clog2(NUM_IN)-1:0]          out_src,
    output logic                               out_head,
    output logic                               out_tail
);
    localparam int NS   = NUM_IN * NUM_CLS;
    localparam int IW   = $clog2(NUM_IN);
    localparam int CLW  = $clog2(NUM_CLS);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [NS-1:0]     hit;
    logic [NUM_IN-1:0] elig [NUM_CLS];
    logic [IW-1:0]     owner [NUM_CLS];
    logic [IW-1:0]     ptr   [NUM_CLS];
    logic [IW-1:0]     start [NUM_CLS];
    logic [IW-1:0]     pick_idx [NUM_CLS];
    logic [CNTW-1:0]   cnt   [NUM_CLS];
    logic [NUM_CLS-1:0] held, pick_found, avail, cls_go, take;

    logic              sel_found;
    logic [CLW-1:0]    sel_cls;
    logic [IW-1:0]     sel_src;
    int                slot;

    // route helper per slot
    for (genvar s = 0; s < NS; s++) begin : g_route
        logic [2:0] dir;
        xy_route #(.CW(CW)) u_rt (
            .cur_x (CW'(MY_X)),
            .cur_y (CW'(MY_Y)),
            .dst_x (in_dst_x[s*CW +: CW]),
            .dst_y (in_dst_y[s*CW +: CW]),
            .dir   (dir)
        );
        assign hit[s] = (dir == 3'(OUT_DIR));
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            localparam int S = i * NUM_CLS + c;
            assign elig[c][i] = in_vld[S] &&
                (held[c] ? ((owner[c] == IW'(i)) && !in_head[S])
                         : (in_head[S] && hit[S]));
        end

        assign start[c] = held[c] ? owner[c] : ptr[c];

        rr_pick #(.N(NUM_IN), .IW(IW)) u_pick (
            .req   (elig[c]),
            .start (start[c]),
            .found (pick_found[c]),
            .win   (pick_idx[c])
        );

        credit_ctr #(.DEPTH(DEPTH), .CNTW(CNTW)) u_crd (
            .clk   (clk),
            .rst   (rst),
            .take  (take[c]),
            .give  (crd_ret[c]),
            .cnt   (cnt[c]),
            .avail (avail[c])
        );

        assign cls_go[c] = pick_found[c] && avail[c];
        assign take[c]   = sel_found && (sel_cls == CLW'(c));

        class_lock #(.N(NUM_IN), .IW(IW)) u_lock (
            .clk      (clk),
            .rst      (rst),
            .win      (take[c]),
            .win_head (out_head),
            .win_tail (out_tail),
            .win_src  (sel_src),
            .held     (held[c]),
            .owner    (owner[c]),
            .ptr      (ptr[c])
        );
    end

    // strict level priority: lowest index wins
    always_comb begin
        sel_found = 1'b0;
        sel_cls   = '0;
        for (int c = NUM_CLS - 1; c >= 0; c--) begin
            if (cls_go[c]) begin
                sel_found = 1'b1;
                sel_cls   = CLW'(c);
            end
        end
    end

    assign sel_src = pick_idx[sel_cls];
    assign slot    = int'(sel_src) * NUM_CLS + int'(sel_cls);

    always_comb begin
        out_vld   = sel_found;
        out_cls   = sel_cls;
        out_src   = sel_src;
        out_grant = '0;
        out_data  = '0;
        out_head  = 1'b0;
        out_tail  = 1'b0;
        if (sel_found) begin
            out_grant[slot] = 1'b1;
            out_data        = in_data[slot*DW +: DW];
            out_head        = in_head[slot];
            out_tail        = in_tail[slot];
        end
    end

    p_onehot_grant_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_grant) && (out_vld == (out_grant != '0)));

    p_granted_valid_r3: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ((in_vld & out_grant) == out_grant));

    p_lock_owner_r7: assert property (@(posedge clk) disable iff (rst)
        (out_vld && held[out_cls]) |-> ((out_src == owner[out_cls]) && !out_head));

    p_credit_gate_r5: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (cnt[out_cls] != '0));
endmodule

// File: tb/tb_qos_port_sched.sv
`timescale 1ns/100ps
module tb_qos_port_sched;
    localparam int NI = 5, NC = 4, DW = 16, CW = 3, NS = NI * NC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS-1:0]    in_vld = '0, in_head = '0, in_tail = '0;
    logic [NS*CW-1:0] in_dst_x = '0, in_dst_y = '0;
    logic [NS*DW-1:0] in_data = '0;
    logic [NC-1:0]    crd_man = '0;
    logic             ret_all = 1'b0;
    logic [NC-1:0]    crd_ret;
    logic [NS-1:0]    out_grant;
    logic             out_vld, out_head, out_tail;
    logic [DW-1:0]    out_data;
    logic [1:0]       out_cls;
    logic [2:0]       out_src;

    int total = 0, bad = 0;

    always #2.5 clk = ~clk;
    assign crd_ret = ret_all ? '1 : crd_man;

    qos_port_sched dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_head(in_head), .in_tail(in_tail),
        .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_data(in_data), .crd_ret(crd_ret),
        .out_grant(out_grant), .out_vld(out_vld), .out_data(out_data), .out_cls(out_cls),
        .out_src(out_src), .out_head(out_head), .out_tail(out_tail));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clr();
        in_vld = '0; in_head = '0; in_tail = '0; crd_man = '0;
    endtask

    task automatic put(int i, int c, bit h, bit t, int dx, int dy);
        int s;
        s = i * NC + c;
        in_vld[s] = 1'b1; in_head[s] = h; in_tail[s] = t;
        in_dst_x[s*CW +: CW] = CW'(dx);
        in_dst_y[s*CW +: CW] = CW'(dy);
        in_data[s*DW +: DW] = 16'hA000 | 16'(i << 4) | 16'(c);
    endtask

    task automatic do_reset();
        clr();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    // checks the grant against an expected (valid, input, level)
    task automatic expect_g(string rq, bit v, int i, int c);
        bit ok;
        logic [NS-1:0] eg;
        logic [DW-1:0] ed;
        #1;
        eg = v ? (NS'(1) << (i * NC + c)) : '0;
        ed = 16'hA000 | 16'(i << 4) | 16'(c);
        ok = (out_vld == v) && (out_grant == eg);
        if (v) ok = ok && (int'(out_src) == i) && (int'(out_cls) == c) && (out_data == ed);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: vld=%0b src=%0d cls=%0d grant=%h data=%h expected vld=%0b src=%0d cls=%0d grant=%h",
                     rq, out_vld, out_src, out_cls, out_grant, out_data, v, i, c, eg);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, idle
        do_reset();
        tick(); clr();
        expect_g("R1 idle after reset", 0, 0, 0);

        // R1/R5: counters start full: DEPTH sends then block
        for (int n = 0; n < 4; n++) begin
            tick(); clr(); put(1, 3, 1, 1, 3, 1);
            expect_g("R1 full credit send", 1, 1, 3);
        end
        tick(); clr(); put(1, 3, 1, 1, 3, 1);
        expect_g("R5 zero credit blocks", 0, 0, 0);
        crd_man[3] = 1'b1;                         // pulse while blocked
        tick(); clr(); put(1, 3, 1, 1, 3, 1);
        expect_g("R6 credit return reopens", 1, 1, 3);
        crd_man[3] = 1'b1;                         // send and return together
        tick(); clr(); put(1, 3, 1, 1, 3, 1);
        expect_g("R6 send+return keeps count", 1, 1, 3);
        tick(); clr(); put(1, 3, 1, 1, 3, 1);
        expect_g("R6 count then zero", 0, 0, 0);

        // R6: saturation at DEPTH
        do_reset();
        for (int n = 0; n < 3; n++) begin
            tick(); clr(); crd_man[3] = 1'b1;
        end
        for (int n = 0; n < 4; n++) begin
            tick(); clr(); put(2, 3, 1, 1, 4, 0);
            expect_g("R6 saturated send", 1, 2, 3);
        end
        tick(); clr(); put(2, 3, 1, 1, 4, 0);
        expect_g("R6 no credit above depth", 0, 0, 0);

        // R5: blocked level yields to a lower-priority level
        do_reset();
        for (int n = 0; n < 4; n++) begin
            tick(); clr(); put(0, 0, 1, 1, 3, 1);
            expect_g("R5 drain level 0", 1, 0, 0);
        end
        tick(); clr(); put(0, 0, 1, 1, 3, 1); put(1, 1, 1, 1, 3, 1);
        expect_g("R5 level 1 passes blocked level 0", 1, 1, 1);

        // R4 sweep: all level mixes from one input
        do_reset();
        ret_all = 1'b1;
        for (int m = 0; m < 16; m++) begin
            int lo;
            lo = -1;
            tick(); clr();
            for (int c = 3; c >= 0; c--) if (m[c]) begin put(0, c, 1, 1, 5, 2); lo = c; end
            expect_g("R4 level priority sweep", lo >= 0, 0, (lo >= 0) ? lo : 0);
        end

        // R2 sweep: every destination; east of (1,1) iff x > 1
        for (int dx = 0; dx < 8; dx++) begin
            for (int dy = 0; dy < 8; dy++) begin
                tick(); clr(); put(2, 1, 1, 1, dx, dy);
                expect_g("R2 XY route match", dx > 1, 2, 1);
            end
        end

        // R9/R3: five single-flit requesters rotate 0..4 twice
        do_reset();
        for (int n = 0; n < 10; n++) begin
            tick(); clr();
            for (int i = 0; i < NI; i++) put(i, 2, 1, 1, 3, 3);
            expect_g("R9 round-robin rotation", 1, n % NI, 2);
        end

        // R9: pointer moves only on tail
        do_reset();
        tick(); clr(); put(3, 2, 1, 0, 3, 0);
        expect_g("R9 head of input 3", 1, 3, 2);
        tick(); clr(); put(3, 2, 0, 1, 0, 0);
        expect_g("R9 tail of input 3", 1, 3, 2);
        tick(); clr(); put(0, 2, 1, 1, 2, 0); put(1, 2, 1, 1, 2, 0); put(4, 2, 1, 1, 2, 0);
        expect_g("R9 search from winner+1", 1, 4, 2);
        tick(); clr(); put(0, 2, 1, 1, 2, 0); put(1, 2, 1, 1, 2, 0);
        expect_g("R9 wrap to input 0", 1, 0, 2);

        // R7/R8/R11: lock with interleaving level 0
        do_reset();
        tick(); clr(); put(0, 1, 1, 0, 3, 1);
        expect_g("R7 head claims level 1", 1, 0, 1);
        tick(); clr(); put(3, 1, 1, 1, 3, 1); put(0, 1, 0, 0, 0, 0); put(4, 0, 1, 1, 3, 1);
        expect_g("R8 level 0 interleaves", 1, 4, 0);
        tick(); clr(); put(3, 1, 1, 1, 3, 1); put(0, 1, 0, 0, 0, 0);
        expect_g("R7 owner body beats rival head", 1, 0, 1);
        tick(); clr(); put(3, 1, 1, 1, 3, 1); put(2, 1, 0, 1, 0, 0);
        expect_g("R11 non-owner tail ignored", 0, 0, 0);
        tick(); clr(); put(3, 1, 1, 1, 3, 1); put(0, 1, 0, 1, 0, 0);
        expect_g("R7 owner tail sent", 1, 0, 1);
        tick(); clr(); put(3, 1, 1, 1, 3, 1);
        expect_g("R7 rival head after release", 1, 3, 1);

        // R10/R11: single-flit packets do not lock
        do_reset();
        tick(); clr(); put(2, 0, 0, 0, 0, 0);
        expect_g("R11 body on free level ignored", 0, 0, 0);
        tick(); clr(); put(0, 0, 1, 1, 3, 1);
        expect_g("R10 single-flit sent", 1, 0, 0);
        tick(); clr(); put(1, 0, 1, 1, 3, 1);
        expect_g("R10 next head not blocked", 1, 1, 0);

        ret_all = 1'b0;
        tick(); clr();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule